// File: doc/BRIEF.md
# Pipelined Sixteen-Key Bitonic Sorter

This block sorts a vector of sixteen unsigned keys into ascending order in a single pass through a fixed network of compare-exchange elements. A whole vector is presented at once together with a valid flag. The sorted vector comes out a fixed number of cycles later, and a new vector can enter on every clock cycle.

The network is built in stages. Stage `s` (1 to 4) applies bitonic merges of size `2^s`. Inside that stage, neighbouring merges point in opposite directions, so each pair of merge outputs forms a bitonic sequence for the next stage. Stage `s` runs `s` comparator columns. Within a column, each wire is paired with the wire whose index differs from it in exactly one bit. That bit falls from `s-1` down to 0 as the columns proceed. The last stage is one increasing merge over all sixteen wires.

A register follows each of the ten columns, and the valid flag travels with the data through every register. The block has no control states: apart from that valid flag, every flop is datapath.

Top module: `bitonic_sorter16`

## Requirements
- R1: While `rst_n` is low, and on every cycle after reset until a vector has been accepted, `out_valid` is 0.
- R2: A vector is accepted on a rising edge where `in_valid` is 1. Its result appears with `out_valid` high exactly 10 rising edges later. Every accepted vector yields exactly one result.
- R3: Key k occupies bits `[8k+7:8k]` of both `in_keys` and `out_keys`. When `out_valid` is high, key k of `out_keys` is not greater than key k+1, so key 0 is the smallest.
- R4: The keys of each result are the same multiset as the keys of the vector that produced it, including their sum.
- R5: Vectors accepted on consecutive cycles come out on consecutive cycles, in the order they were accepted.
- R6: A cycle with `in_valid` low produces no result. Gaps in the input stream reappear unchanged, 10 cycles later, as cycles with `out_valid` low.
- R7: In stage s and column step j, wire i with bit j clear is compared with wire i+2^j. For stages 1 to 3 the comparator is increasing (minimum on wire i) when bit s of i is 0 and decreasing when it is 1. Every comparator in stage 4 is increasing.
- R8: Repeated keys, and the extreme values 0x00 and 0xFF, are sorted correctly. Equal keys may swap places.
- R9: The input 3,5,8,9,10,12,14,20,95,90,60,40,35,23,18,0 (key 0 first) produces 0,3,5,8,9,10,12,14,18,20,23,35,40,60,90,95.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | `in_keys` holds a vector to sort this cycle |
| in_keys | input | 128 | Sixteen 8-bit unsigned keys, key 0 in the low byte |
| out_valid | output | 1 | `out_keys` holds a sorted result |
| out_keys | output | 128 | Sorted keys, smallest in the low byte |

## Verification
The bench drives every one of the 65536 vectors whose keys are only 0x00 and 0xFF, back to back. By the zero-one principle, any comparator with the wrong direction or the wrong partner shows up here as a vector that is not sorted. The same sweep catches a stage with the wrong direction pattern, which would leave the final merge with a sequence that is not bitonic. Separate runs with random keys, all-equal keys and the bitonic example catch broken comparisons and dropped or duplicated keys. Random gaps in `in_valid` catch a valid flag that is lost, late or early; the failure appears as a missing result, an unexpected result or one off by a cycle.

// File: rtl/bsort_pkg.sv
package bsort_pkg;
    localparam int unsigned DEF_KEY_W = 8;
    localparam int unsigned DEF_LOG_N = 4;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } cmp_dir_e;

    function automatic int unsigned column_total(input int unsigned lg);
        return lg * (lg + 1) / 2;
    endfunction
endpackage

// File: rtl/bsort_cmp.sv
module bsort_cmp
    import bsort_pkg::*;
#(
    parameter int unsigned KEY_W = DEF_KEY_W,
    parameter cmp_dir_e    DIR   = DIR_UP
) (
    input  logic [KEY_W-1:0] a_i,
    input  logic [KEY_W-1:0] b_i,
    output logic [KEY_W-1:0] upper_o,
    output logic [KEY_W-1:0] lower_o
);
    logic a_le_b;
    assign a_le_b = (a_i <= b_i);

    generate
        if (DIR == DIR_UP) begin : g_up
            assign upper_o = a_le_b ? a_i : b_i;
            assign lower_o = a_le_b ? b_i : a_i;
        end else begin : g_down
            assign upper_o = a_le_b ? b_i : a_i;
            assign lower_o = a_le_b ? a_i : b_i;
        end
    endgenerate
endmodule

// File: rtl/bsort_column.sv
module bsort_column
    import bsort_pkg::*;
#(
    parameter int unsigned KEY_W = DEF_KEY_W,
    parameter int unsigned LOG_N = DEF_LOG_N,
    parameter int unsigned STAGE = 1,
    parameter int unsigned STEP  = 0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [(KEY_W<<LOG_N)-1:0]     in_keys,
    output logic                          out_valid,
    output logic [(KEY_W<<LOG_N)-1:0]     out_keys
);
    localparam int unsigned N   = 1 << LOG_N;
    localparam int unsigned SW  = KEY_W + LOG_N;
    localparam int unsigned GAP = 1 << STEP;

    logic [KEY_W-1:0] in_arr  [N];
    logic [KEY_W-1:0] nxt_arr [N];

    generate
        for (genvar i = 0; i < N; i++) begin : g_wire
            assign in_arr[i] = in_keys[i*KEY_W +: KEY_W];
            if (((i >> STEP) & 1) == 0) begin : g_pair
                localparam int unsigned P = i + GAP;
                localparam cmp_dir_e D = (STAGE == LOG_N) ? DIR_UP :
                    ((((i >> STAGE) & 1) == 0) ? DIR_UP : DIR_DOWN);

                bsort_cmp #(.KEY_W(KEY_W), .DIR(D)) cmp_i (
                    .a_i     (in_arr[i]),
                    .b_i     (in_arr[P]),
                    .upper_o (nxt_arr[i]),
                    .lower_o (nxt_arr[P])
                );

                // R7
                pair_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    out_valid |-> ((D == DIR_UP)
                        ? (out_keys[i*KEY_W +: KEY_W] <= out_keys[P*KEY_W +: KEY_W])
                        : (out_keys[i*KEY_W +: KEY_W] >= out_keys[P*KEY_W +: KEY_W])));
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (in_valid) begin
            for (int k = 0; k < N; k++) begin
                out_keys[k*KEY_W +: KEY_W] <= nxt_arr[k];
            end
        end
    end

    logic [SW-1:0] in_sum;
    logic [SW-1:0] out_sum;
    always_comb begin
        in_sum  = '0;
        out_sum = '0;
        for (int k = 0; k < N; k++) begin
            in_sum  = in_sum  + SW'(in_arr[k]);
            out_sum = out_sum + SW'(out_keys[k*KEY_W +: KEY_W]);
        end
    end

    // R4
    key_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sum == $past(in_sum)));
endmodule

// File: rtl/bitonic_sorter16.sv
module bitonic_sorter16
    import bsort_pkg::*;
#(
    parameter int unsigned KEY_W = DEF_KEY_W,
    parameter int unsigned LOG_N = DEF_LOG_N
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [(KEY_W<<LOG_N)-1:0] in_keys,
    output logic                      out_valid,
    output logic [(KEY_W<<LOG_N)-1:0] out_keys
);
    localparam int unsigned N    = 1 << LOG_N;
    localparam int unsigned VW   = KEY_W * N;
    localparam int unsigned NCOL = column_total(LOG_N);
    localparam int unsigned CW   = $clog2(NCOL + 2);

    logic [VW-1:0] pipe_keys [NCOL+1];
    logic          pipe_vld  [NCOL+1];

    assign pipe_keys[0] = in_keys;
    assign pipe_vld[0]  = in_valid;

    generate
        for (genvar s = 1; s <= LOG_N; s++) begin : g_stage
            for (genvar t = 0; t < s; t++) begin : g_step
                localparam int unsigned C = s * (s - 1) / 2 + t;
                bsort_column #(
                    .KEY_W (KEY_W),
                    .LOG_N (LOG_N),
                    .STAGE (s),
                    .STEP  (s - 1 - t)
                ) col_i (
                    .clk       (clk),
                    .rst_n     (rst_n),
                    .in_valid  (pipe_vld[C]),
                    .in_keys   (pipe_keys[C]),
                    .out_valid (pipe_vld[C+1]),
                    .out_keys  (pipe_keys[C+1])
                );
            end
        end
    endgenerate

    assign out_valid = pipe_vld[NCOL];
    assign out_keys  = pipe_keys[NCOL];

    function automatic logic is_ascending(input logic [VW-1:0] v);
        for (int k = 1; k < N; k++) begin
            if (v[k*KEY_W +: KEY_W] < v[(k-1)*KEY_W +: KEY_W]) return 1'b0;
        end
        return 1'b1;
    endfunction

    // R3
    sorted_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> is_ascending(out_keys));

    logic [CW-1:0] inflight;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inflight <= '0;
        end else begin
            inflight <= inflight + CW'(in_valid) - CW'(out_valid);
        end
    end

    // R6
    no_orphan_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (inflight != '0));

    // R2
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= CW'(NCOL));

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inflight == '0) |-> !out_valid);
endmodule

// File: tb/bitonic_sorter16_tb_top.sv
`timescale 1ns/1ps
module bitonic_sorter16_tb_top;
    localparam int LAT = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] in_keys = '0;
    logic         out_valid;
    logic [127:0] out_keys;

    bitonic_sorter16 dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_keys   (in_keys),
        .out_valid (out_valid),
        .out_keys  (out_keys)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;
    logic [127:0] exp_ring [32];
    int           cyc_ring [32];
    int wr = 0;
    int rd = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] ref_sort(input logic [127:0] v);
        logic [7:0] a [16];
        logic [7:0] tmp;
        logic [127:0] r;
        for (int k = 0; k < 16; k++) a[k] = v[k*8 +: 8];
        for (int k = 1; k < 16; k++) begin
            for (int m = k; m > 0; m--) begin
                if (a[m] < a[m-1]) begin
                    tmp = a[m]; a[m] = a[m-1]; a[m-1] = tmp;
                end
            end
        end
        for (int k = 0; k < 16; k++) r[k*8 +: 8] = a[k];
        return r;
    endfunction

    task automatic push(input logic [127:0] v, input logic [127:0] e);
        @(negedge clk);
        in_valid = 1'b1;
        in_keys  = v;
        exp_ring[wr % 32] = e;
        cyc_ring[wr % 32] = cyc;
        wr++;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_keys  = '0;
        end
    endtask

    // monitor: R2, R3, R4, R5, R6
    always @(negedge clk) begin
        if (mon_en) begin
            if (rd != wr && cyc_ring[rd % 32] + LAT == cyc) begin
                chk(out_valid, "R2 latency", {127'd0, out_valid}, 128'd1);
                chk(out_keys === exp_ring[rd % 32], "R3/R4/R5 keys",
                    out_keys, exp_ring[rd % 32]);
                rd++;
            end else if (out_valid) begin
                chk(1'b0, "R6 spurious", {127'd0, out_valid}, 128'd0);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [127:0] v;
        logic [127:0] e;
        logic [31:0]  lfsr;
        int ones;

        repeat (3) @(negedge clk);
        // R1: reset held low
        chk(out_valid == 1'b0, "R1 in reset", {127'd0, out_valid}, 128'd0);
        rst_n = 1'b1;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R1 idle after reset", {127'd0, out_valid}, 128'd0);
        end
        mon_en = 1'b1;

        // R9: given bitonic example
        v = {8'd0, 8'd18, 8'd23, 8'd35, 8'd40, 8'd60, 8'd90, 8'd95,
             8'd20, 8'd14, 8'd12, 8'd10, 8'd9, 8'd8, 8'd5, 8'd3};
        e = {8'd95, 8'd90, 8'd60, 8'd40, 8'd35, 8'd23, 8'd20, 8'd18,
             8'd14, 8'd12, 8'd10, 8'd9, 8'd8, 8'd5, 8'd3, 8'd0};
        push(v, e);
        // R8: repeated and extreme keys
        push({16{8'h5A}}, {16{8'h5A}});
        push({16{8'hFF}}, {16{8'hFF}});
        v = {8'h00, 8'hFF, 8'h00, 8'hFF, 8'h07, 8'h07, 8'h07, 8'h01,
             8'hFF, 8'h00, 8'h80, 8'h80, 8'h07, 8'h00, 8'hFF, 8'h01};
        push(v, ref_sort(v));
        for (int k = 0; k < 16; k++) v[k*8 +: 8] = 8'(15 - k);
        push(v, ref_sort(v));
        idle(LAT + 3);

        // R7, R5: every zero/one vector, back to back
        for (int p = 0; p < 65536; p++) begin
            ones = $countones(p[15:0]);
            for (int k = 0; k < 16; k++) begin
                v[k*8 +: 8] = p[k] ? 8'hFF : 8'h00;
                e[k*8 +: 8] = (k >= 16 - ones) ? 8'hFF : 8'h00;
            end
            push(v, e);
        end
        idle(LAT + 3);

        // R4, R6: random keys with random gaps
        lfsr = 32'h1234_5678;
        for (int n = 0; n < 300; n++) begin
            for (int k = 0; k < 4; k++) begin
                lfsr = lfsr ^ (lfsr << 13);
                lfsr = lfsr ^ (lfsr >> 17);
                lfsr = lfsr ^ (lfsr << 5);
                v[k*32 +: 32] = lfsr;
            end
            push(v, ref_sort(v));
            if (lfsr[3]) idle(1 + int'(lfsr[9:8]));
        end
        idle(LAT + 5);

        // R2: every accepted vector produced a result; R6: pipeline empty
        chk(rd == wr, "R2 all results", 128'(rd), 128'(wr));
        chk(out_valid == 1'b0, "R6 drained", {127'd0, out_valid}, 128'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule